// File: doc/BRIEF.md
# Cascaded Serial Configuration Loader

This block takes a device's configuration word as a serial bit stream on a serial clock that it shares with the other devices in the chain. Devices are cascaded by connecting each device's active-low enable output to the next device's active-low enable input. The first device in the chain has its enable input driven externally. A device accepts bits only while its enable input is low. Once it holds its full word, it pulls its enable output low so the next device starts taking bits from the same data line. From then on, its enable output simply mirrors its enable input.

The rest of the device sees the parallel configuration word and a done flag. Nothing downstream, such as read-queue selection, may act until the done flag is set, which is also when the enable output is first allowed to go low. A single strap input chooses serial loading. When the strap selects parallel loading, this loader stays idle.

Top module: `cfg_chain_loader`

## Requirements
- R1: While rst_ni is low, cfg_o is all zeros, done_o is 0 and sen_no is 1.
- R2: A bit is captured on a rising clk_i edge only when sen_ni is 0. While sen_ni is 1, cfg_o does not change.
- R3: Bits fill cfg_o LSB first. The k-th accepted bit (k counted from 0) ends up in cfg_o[k] once CFG_W bits have been accepted.
- R4: done_o rises on the edge that captures the CFG_W-th accepted bit, and not earlier.
- R5: While done_o is 0, sen_no is 1 whatever the value of sen_ni.
- R6: While done_o is 1, sen_no equals sen_ni combinationally, with no clock edge needed.
- R7: Once done_o is 1, further edges change neither cfg_o nor done_o until the next reset.
- R8: With serial_mode_i at 0 (parallel strap), no bit is accepted, done_o stays 0 and sen_no stays 1.
- R9: In a chain of two loaders fed from one data line, the first CFG_W accepted bits load the first device and the next CFG_W bits load the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared serial clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| serial_mode_i | input | 1 | Strap: 1 selects serial loading, 0 selects parallel loading (loader idle); held stable |
| sdata_i | input | 1 | Serial configuration data |
| sen_ni | input | 1 | Active-low serial enable from the previous device or from the host |
| sen_no | output | 1 | Active-low serial enable to the next device |
| cfg_o | output | CFG_W | Parallel configuration word |
| done_o | output | 1 | Configuration load complete |

## Verification
The bound checker examines these properties on every cycle:
- sen_no is held high before completion, and it tracks sen_ni afterwards.
- cfg_o holds steady while the enable is high, and it stays frozen after completion.
- done_o only rises on an enabled edge.
- The loader stays idle under the parallel strap.

Some behaviour can only be shown by the bench's scenarios, using two chained instances fed with random words and random enable gaps:
- the bit ordering inside the word;
- completion on exactly the CFG_W-th accepted bit;
- the handoff of the shared stream to the downstream device.

// File: rtl/cfg_load_pkg.sv
`timescale 1ns/1ps
package cfg_load_pkg;
  typedef enum logic [1:0] {
    PH_PARALLEL = 2'd0,
    PH_LOADING  = 2'd1,
    PH_DONE     = 2'd2
  } load_phase_e;
endpackage

// File: rtl/cfg_bit_counter.sv
`timescale 1ns/1ps
module cfg_bit_counter #(
  parameter int unsigned CFG_W = 64,
  localparam int unsigned CNT_W = (CFG_W > 2) ? $clog2(CFG_W) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic advance_i,
  output logic last_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (advance_i) count_q <= count_q + 1'b1;
  end

  assign last_o = (count_q == CNT_W'(CFG_W - 1));
endmodule

// File: rtl/cfg_shift_reg.sv
`timescale 1ns/1ps
module cfg_shift_reg #(
  parameter int unsigned CFG_W     = 64,
  parameter bit          LSB_FIRST = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [CFG_W-1:0] word_o
);
  logic [CFG_W-1:0] word_q, word_d;

  generate
    if (LSB_FIRST) begin : g_lsb
      // newest bit enters at the top, first bit drifts to bit 0
      assign word_d = {bit_i, word_q[CFG_W-1:1]};
    end else begin : g_msb
      assign word_d = {word_q[CFG_W-2:0], bit_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (shift_i) word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/cfg_chain_enable.sv
`timescale 1ns/1ps
module cfg_chain_enable
  import cfg_load_pkg::*;
(
  input  load_phase_e phase_i,
  input  logic        sen_ni,
  output logic        sen_no
);
  always_comb begin
    unique case (phase_i)
      PH_DONE: sen_no = sen_ni;
      default: sen_no = 1'b1;
    endcase
  end
endmodule

// File: rtl/cfg_chain_loader.sv
`timescale 1ns/1ps
module cfg_chain_loader
  import cfg_load_pkg::*;
#(
  parameter int unsigned CFG_W     = 64,
  parameter bit          LSB_FIRST = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             serial_mode_i,
  input  logic             sdata_i,
  input  logic             sen_ni,
  output logic             sen_no,
  output logic [CFG_W-1:0] cfg_o,
  output logic             done_o
);
  logic        done_q;
  logic        accept;
  logic        last_bit;
  load_phase_e phase;

  always_comb begin
    if (!serial_mode_i) phase = PH_PARALLEL;
    else if (done_q)    phase = PH_DONE;
    else                phase = PH_LOADING;
  end

  assign accept = (phase == PH_LOADING) && !sen_ni;

  cfg_bit_counter #(.CFG_W(CFG_W)) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (accept),
    .last_o    (last_bit)
  );

  cfg_shift_reg #(.CFG_W(CFG_W), .LSB_FIRST(LSB_FIRST)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (accept),
    .bit_i   (sdata_i),
    .word_o  (cfg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 done_q <= 1'b0;
    else if (accept && last_bit) done_q <= 1'b1;
  end

  cfg_chain_enable i_enable (
    .phase_i (phase),
    .sen_ni  (sen_ni),
    .sen_no  (sen_no)
  );

  assign done_o = done_q;
endmodule

// File: rtl/cfg_chain_loader_chk.sv
`timescale 1ns/1ps
module cfg_chain_loader_chk #(
  parameter int unsigned CFG_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             serial_mode_i,
  input logic             sen_ni,
  input logic             sen_no,
  input logic [CFG_W-1:0] cfg_o,
  input logic             done_o
);
  p_hold_when_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_ni |=> $stable(cfg_o));

  p_done_on_enabled_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(!sen_ni && serial_mode_i));

  p_oe_high_before_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> sen_no);

  p_oe_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sen_no == sen_ni));

  p_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(cfg_o)));

  p_parallel_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!serial_mode_i && !done_o) |=> (!done_o && $stable(cfg_o)));
endmodule

bind cfg_chain_loader cfg_chain_loader_chk #(.CFG_W(CFG_W)) i_chk (.*);

// File: tb/test_cfg_chain_loader.sv
`timescale 1ns/1ps
module test_cfg_chain_loader;
  localparam int unsigned W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode = 1'b1;
  logic         sdata = 1'b0;
  logic         sen_a = 1'b1;
  logic         sen_ab, sen_no_b;
  logic [W-1:0] cfg_a, cfg_b;
  logic         done_a, done_b;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cfg_chain_loader #(.CFG_W(W)) i_cfg_chain_loader (
    .clk_i(clk), .rst_ni(rst_n), .serial_mode_i(mode), .sdata_i(sdata),
    .sen_ni(sen_a), .sen_no(sen_ab), .cfg_o(cfg_a), .done_o(done_a));

  cfg_chain_loader #(.CFG_W(W)) i_cfg_chain_loader_b (
    .clk_i(clk), .rst_ni(rst_n), .serial_mode_i(mode), .sdata_i(sdata),
    .sen_ni(sen_ab), .sen_no(sen_no_b), .cfg_o(cfg_b), .done_o(done_b));

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
      finish_run();
    end
  end

  task automatic check(input logic ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rand_word();
    return {$urandom(), $urandom()};
  endfunction

  task automatic step(input logic sen, input logic sd);
    @(negedge clk);
    sen_a = sen;
    sdata = sd;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n = 1'b0;
    mode = m;
    sen_a = 1'b1;
    #1;
    check(cfg_a == '0 && done_a == 1'b0 && sen_ab == 1'b1, "R1", {cfg_a[W-3:0], done_a, sen_ab}, 1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // feed W accepted bits; gaps drive sen_a high with garbage data
  // sel 0: device A is loading, sel 1: device B is loading (A already done)
  task automatic load_word(input logic [W-1:0] w, input bit gaps, input bit sel);
    logic [W-1:0] cfg_before;
    int idx = 0;
    while (idx < W) begin
      if (gaps && ($urandom() % 4 == 0)) begin
        cfg_before = sel ? cfg_b : cfg_a;
        step(1'b1, 1'($urandom()));
        check((sel ? cfg_b : cfg_a) == cfg_before, "R2",
              sel ? cfg_b : cfg_a, cfg_before);
        if (!sel) check(sen_ab == 1'b1, "R5", W'(sen_ab), 1);
      end else begin
        step(1'b0, w[idx]);
        idx++;
        if (idx == W - 1)
          check((sel ? done_b : done_a) == 1'b0, "R4", W'(sel ? done_b : done_a), 0);
        if (!sel && idx < W) check(sen_ab == 1'b1, "R5", W'(sen_ab), 1);
      end
    end
    check((sel ? done_b : done_a) == 1'b1, "R4", W'(sel ? done_b : done_a), 1);
  endtask

  initial begin
    logic [W-1:0] w1, w2, w3;
    void'($urandom(32'd9137));
    w1 = rand_word();
    w2 = rand_word();
    w3 = rand_word();

    // serial mode, two-device chain
    do_reset(1'b1);
    check(cfg_b == '0 && done_b == 1'b0 && sen_no_b == 1'b1, "R1", cfg_b, '0);
    load_word(w1, 1'b1, 1'b0);
    check(cfg_a == w1, "R3", cfg_a, w1);
    check(cfg_b == '0 && done_b == 1'b0, "R9", cfg_b, '0);

    // pass-through after completion, no clock needed
    @(negedge clk);
    sen_a = 1'b1; #0.5;
    check(sen_ab == 1'b1, "R6", W'(sen_ab), 1);
    sen_a = 1'b0; #0.5;
    check(sen_ab == 1'b0, "R6", W'(sen_ab), 0);
    sen_a = 1'b1; #0.5;
    check(sen_ab == 1'b1, "R6", W'(sen_ab), 1);

    // downstream device takes the next word
    load_word(w2, 1'b1, 1'b1);
    check(cfg_b == w2, "R9", cfg_b, w2);
    check(cfg_a == w1 && done_a, "R7", cfg_a, w1);
    step(1'b0, 1'b1);
    check(sen_no_b == 1'b0, "R6", W'(sen_no_b), 0);
    repeat (10) step(1'b0, 1'($urandom()));
    check(cfg_a == w1 && cfg_b == w2, "R7", cfg_b, w2);

    // corner patterns: alternating bits, no gaps
    do_reset(1'b1);
    load_word({(W/2){2'b01}}, 1'b0, 1'b0);
    check(cfg_a == {(W/2){2'b01}}, "R3", cfg_a, {(W/2){2'b01}});
    check(cfg_a[0] == 1'b1 && cfg_a[W-1] == 1'b0, "R3", cfg_a, {(W/2){2'b01}});

    // parallel strap: loader idle
    do_reset(1'b0);
    repeat (W + 16) step(1'b0, 1'b1);
    check(cfg_a == '0 && done_a == 1'b0, "R8", cfg_a, '0);
    check(sen_ab == 1'b1 && cfg_b == '0 && done_b == 1'b0, "R8", W'(sen_ab), 1);

    // second random serial run through the chain
    do_reset(1'b1);
    load_word(w3, 1'b1, 1'b0);
    load_word(~w3, 1'b0, 1'b1);
    check(cfg_a == w3, "R3", cfg_a, w3);
    check(cfg_b == ~w3, "R9", cfg_b, ~w3);

    finish_run();
  end
endmodule